// File: doc/BRIEF.md
# Split-Read Result Register Lock

This block holds a 10-bit conversion result that software fetches as two byte-wide reads. The low byte presents result bits 7:0. The high byte presents bits 9:8 in its two lowest positions, and its upper six bits read as zero. The block makes sure the two bytes always come from the same conversion. Once software reads the low byte, the held result is frozen against hardware writes until software reads the high byte.

A conversion that completes while the result is frozen is thrown away. It still raises the completion interrupt flag, and it also sets a sticky lost-result flag that stays set until software clears it. The converter and the bus address decode are outside this block. The block sees only a write strobe carrying the result, the two read strobes, and two clear strobes.

Top module: `resultLock`

## Requirements
- R10: After reset, both read bytes are 0, both flags are 0 and the block is unlocked.
- R1: A write that is accepted shows up on the outputs in the following cycle. lowData carries wrData[7:0], highData[1:0] carries wrData[9:8], and highData[7:2] is 0.
- R2: A rdLow pulse locks the result, starting from the next cycle.
- R3: While the result is locked, a write is discarded. lowData and highData keep their values.
- R4: A rdHigh pulse with no rdLow in the same cycle releases the lock from the next cycle on. After that, writes are accepted again.
- R5: irqFlag sets on every write, whether that write is accepted or discarded. It stays set until an irqClr pulse clears it. If a write and irqClr arrive in the same cycle, the flag ends up set.
- R6: lostFlag sets on every discarded write. It stays set until a lostClr pulse clears it. If a discarded write and lostClr arrive in the same cycle, the flag ends up set.
- R7: A rdHigh pulse while unlocked does not change the lock state, so the next write is accepted.
- R8: A write in the same cycle as rdHigh, while locked, is discarded. The lock is still released after that cycle.
- R9: A write in the same cycle as rdLow, while unlocked, is discarded and sets lostFlag. The lock takes effect as normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Conversion-complete strobe |
| wrData | input | 10 | Conversion result |
| rdLow | input | 1 | Low-byte read strobe |
| rdHigh | input | 1 | High-byte read strobe |
| irqClr | input | 1 | Clears irqFlag |
| lostClr | input | 1 | Clears lostFlag |
| lowData | output | 8 | Result bits 7:0 |
| highData | output | 8 | Result bits 9:8 in bits 1:0, with zeros above |
| irqFlag | output | 1 | Completion interrupt flag |
| lostFlag | output | 1 | Sticky discarded-result flag |

## Verification
Two pairs of events can land in the same cycle: a conversion write with a high-byte read, and a conversion write with a low-byte read. The bench drives each pair on a single clock edge. It then checks that the data bytes hold their old value and that both flags are raised. Finally it sends one more write and checks that acceptance follows the expected lock state. The bench also pairs a write with an interrupt clear and checks that the set takes priority.

// File: rtl/resultLockPkg.sv
package resultLockPkg;
  localparam int RES_W  = 10;
  localparam int BYTE_W = 8;
  localparam int HI_W   = RES_W - BYTE_W;

  typedef struct packed {
    logic load;
  } lockStrobes_t;
endpackage

// File: rtl/resultLockCtl.sv
module resultLockCtl
  import resultLockPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrValid,
  input  logic         rdLow,
  input  logic         rdHigh,
  input  logic         irqClr,
  input  logic         lostClr,
  output lockStrobes_t strobes,
  output logic         irqFlag,
  output logic         lostFlag
);
  logic lockQ;
  logic blocked;

  // A same-cycle low read blocks the write, so the two bytes always stay coherent.
  assign blocked      = lockQ | rdLow;
  assign strobes.load = wrValid & ~blocked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockQ    <= 1'b0;
      irqFlag  <= 1'b0;
      lostFlag <= 1'b0;
    end else begin
      if (rdLow)       lockQ <= 1'b1;
      else if (rdHigh) lockQ <= 1'b0;

      if (wrValid)     irqFlag <= 1'b1;
      else if (irqClr) irqFlag <= 1'b0;

      if (wrValid && blocked) lostFlag <= 1'b1;
      else if (lostClr)       lostFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/resultLockDp.sv
module resultLockDp
  import resultLockPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  lockStrobes_t      strobes,
  input  logic [RES_W-1:0]  wrData,
  output logic [BYTE_W-1:0] lowData,
  output logic [BYTE_W-1:0] highData
);
  logic [RES_W-1:0] resultQ;

  always_ff @(posedge clk) begin
    if (!rstN)             resultQ <= '0;
    else if (strobes.load) resultQ <= wrData;
  end

  assign lowData  = resultQ[BYTE_W-1:0];
  assign highData = {{(BYTE_W-HI_W){1'b0}}, resultQ[RES_W-1:BYTE_W]};
endmodule

// File: rtl/resultLock.sv
module resultLock
  import resultLockPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [RES_W-1:0]  wrData,
  input  logic              rdLow,
  input  logic              rdHigh,
  input  logic              irqClr,
  input  logic              lostClr,
  output logic [BYTE_W-1:0] lowData,
  output logic [BYTE_W-1:0] highData,
  output logic              irqFlag,
  output logic              lostFlag
);
  lockStrobes_t strobes;

  resultLockCtl u_ctl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdLow(rdLow), .rdHigh(rdHigh),
    .irqClr(irqClr), .lostClr(lostClr), .strobes(strobes),
    .irqFlag(irqFlag), .lostFlag(lostFlag)
  );

  resultLockDp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .lowData(lowData), .highData(highData)
  );
endmodule

// File: rtl/resultLockChecker.sv
module resultLockChecker
  import resultLockPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic [RES_W-1:0]  wrData,
  input logic              rdLow,
  input logic              rdHigh,
  input logic              lockQ,
  input logic [BYTE_W-1:0] lowData,
  input logic [BYTE_W-1:0] highData,
  input logic              irqFlag,
  input logic              lostFlag
);
  AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !lockQ && !rdLow) |=> (lowData == $past(wrData[BYTE_W-1:0])) &&
      (highData == {{(BYTE_W-HI_W){1'b0}}, $past(wrData[RES_W-1:BYTE_W])})); // R1
  AST_LOW_READ_LOCKS: assert property (@(posedge clk) disable iff (!rstN)
    rdLow |=> lockQ); // R2
  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    lockQ |=> ($stable(lowData) && $stable(highData))); // R3
  AST_HIGH_READ_UNLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (rdHigh && !rdLow) |=> !lockQ); // R4
  AST_IRQ_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> irqFlag); // R5
  AST_LOST_ON_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && (lockQ || rdLow)) |=> lostFlag); // R6
endmodule

bind resultLock resultLockChecker u_chk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData), .rdLow(rdLow),
  .rdHigh(rdHigh), .lockQ(u_ctl.lockQ), .lowData(lowData), .highData(highData),
  .irqFlag(irqFlag), .lostFlag(lostFlag)
);

// File: tb/resultLock_bench.sv
module resultLock_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] lo;
    logic [7:0] hi;
    logic       irq;
    logic       lost;
    string      tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 1'b0, rdLow = 1'b0, rdHigh = 1'b0, irqClr = 1'b0, lostClr = 1'b0;
  logic [9:0] wrData = '0;
  logic [7:0] lowData, highData;
  logic irqFlag, lostFlag;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  expItem_t q[$];

  logic [9:0] mRes = '0;
  logic mLock = 1'b0, mIrq = 1'b0, mLost = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resultLock u_resultLock (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData), .rdLow(rdLow),
    .rdHigh(rdHigh), .irqClr(irqClr), .lostClr(lostClr), .lowData(lowData),
    .highData(highData), .irqFlag(irqFlag), .lostFlag(lostFlag)
  );

  function automatic void pushExp(string tag);
    expItem_t e;
    e.lo = mRes[7:0];
    e.hi = {6'b0, mRes[9:8]};
    e.irq = mIrq;
    e.lost = mLost;
    e.tag = tag;
    q.push_back(e);
  endfunction

  task automatic step(input logic wv, input logic [9:0] wd, input logic rl,
                      input logic rh, input logic ic, input logic lc, input string tag);
    logic blocked;
    @(negedge clk);
    wrValid = wv; wrData = wd; rdLow = rl; rdHigh = rh; irqClr = ic; lostClr = lc;
    blocked = mLock | rl;
    if (wv) mIrq = 1'b1;
    else if (ic) mIrq = 1'b0;
    if (wv && blocked) mLost = 1'b1;
    else if (lc) mLost = 1'b0;
    if (wv && !blocked) mRes = wd;
    if (rl) mLock = 1'b1;
    else if (rh) mLock = 1'b0;
    pushExp(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      expItem_t e;
      e = q.pop_front();
      compared++;
      if (lowData !== e.lo || highData !== e.hi || irqFlag !== e.irq || lostFlag !== e.lost) begin
        mismatched++;
        $display("FAIL %s: got lo=%h hi=%h irq=%b lost=%b expected lo=%h hi=%h irq=%b lost=%b",
                 e.tag, lowData, highData, irqFlag, lostFlag, e.lo, e.hi, e.irq, e.lost);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    step(0, 10'h000, 0, 0, 0, 0, "R10 reset state");
    step(1, 10'h2A5, 0, 0, 0, 0, "R1 write split into bytes");
    step(0, 10'h000, 0, 0, 1, 0, "R5 irq cleared");
    step(0, 10'h000, 0, 1, 0, 0, "R7 lone high read");
    step(1, 10'h155, 0, 0, 0, 0, "R7 write after lone high read");
    step(0, 10'h000, 1, 0, 0, 0, "R2 low read locks");
    step(1, 10'h3FF, 0, 0, 0, 0, "R3 write dropped while locked");
    step(0, 10'h000, 0, 0, 1, 0, "R5 clear irq");
    step(1, 10'h0C3, 0, 0, 0, 0, "R5 irq on dropped write");
    step(1, 10'h2EE, 0, 1, 0, 0, "R8 write with high read dropped");
    step(0, 10'h000, 0, 0, 0, 1, "R6 lost cleared");
    step(1, 10'h0F0, 0, 0, 0, 0, "R4 write accepted after unlock");
    step(1, 10'h301, 1, 0, 0, 0, "R9 write with low read dropped");
    step(1, 10'h07A, 0, 0, 0, 1, "R6 drop beats lost clear");
    step(0, 10'h000, 0, 1, 0, 0, "R4 high read unlocks");
    step(1, 10'h1B4, 0, 0, 1, 1, "R5 write beats irq clear");
    step(1, 10'h3C7, 0, 0, 0, 0, "R1 second accepted write");
    step(0, 10'h000, 0, 0, 0, 0, "R1 hold");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule